// File: doc/BRIEF.md
# Center-Aligned PWM Generator

This block produces one pulse-width-modulated output from a 10-bit counter that advances on an external tick strobe, so any prescaler lives outside it. A mode input picks between two waveform shapes. In edge-aligned operation the counter climbs from zero to the period value and wraps. In symmetric operation the counter climbs to the period value, holds it for a second tick, falls back to zero and holds zero for a second tick. The pulse then sits centred on the counter peak, and both the period and the pulse width come out twice as long as in edge-aligned operation.

Period, duty and mode are sampled from the inputs into active copies only at a period boundary, so software may change them at any time without producing a torn cycle. While the block is disabled the counter rests at zero, the active copies follow the inputs directly, and the output sits at its idle level. A polarity input decides whether the pulse is driven high or low, and it acts at once.

Top module: `cpwm_gen`

## Requirements
- R1: While enable is low (and after reset), cnt_out is 0 on the next cycle and pwm_out equals the inverse of pol_high; the counter restarts counting upward when enabled.
- R2: The counter changes only on a clock edge where tick_en is high; with tick_en low it holds its value.
- R3: With mode_b2b = 0 the counter goes 0,1,…,P and then back to 0, a period of P+1 ticks, where P is the active period.
- R4: With mode_b2b = 0 the pulse is active while the counter is at most D, which is D+1 ticks per period, where D is the active duty.
- R5: With mode_b2b = 1 the counter goes 0,1,…,P,P,P-1,…,0,0,1,…, giving a period of 2(P+1) ticks with each endpoint held for two ticks.
- R6: With mode_b2b = 1 the pulse is active while the counter is at least P-D, which is 2(D+1) ticks centred on the peak.
- R7: If D is greater than or equal to P, the pulse stays active for the whole period in either mode.
- R8: pol_high = 1 drives the active part of the period high; pol_high = 0 drives it low. The change takes effect in the same cycle.
- R9: New period_in, duty_in and mode_b2b values become active only when a period ends (a wrap in edge-aligned mode, or leaving zero after the down-count in symmetric mode), or on any cycle while disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Counter advance strobe from an external prescaler |
| enable | input | 1 | Run the generator; low forces idle |
| mode_b2b | input | 1 | 0 edge-aligned, 1 symmetric up/down |
| pol_high | input | 1 | 1 active-high pulse, 0 active-low pulse |
| period_in | input | 10 | Requested period value P |
| duty_in | input | 10 | Requested duty value D |
| pwm_out | output | 1 | PWM output |
| cnt_out | output | 10 | Current counter value |

## Verification
The reload of period, duty and mode can fall in the same cycle as the counter's turn at a period end, and a tick gap can fall exactly on an endpoint hold in symmetric mode. The bench sweeps every small period and duty pairing in both modes and both polarities, changing the inputs at an arbitrary position within the running period and thinning the ticks with a fixed gap pattern, so that input changes and tick gaps land on every phase, the boundary included. A position-based model in the bench decides which settings are in force and what the counter and output must show, and it judges every cycle.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

endpackage

// File: rtl/cpwm_counter.sv
module cpwm_counter
    import cpwm_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         enable,
    input  logic         b2b,
    input  logic [W-1:0] period,
    output logic [W-1:0] cnt,
    output dir_e         dir,
    output logic         bnd
);

    typedef struct packed {
        logic [W-1:0] cnt;
        dir_e         dir;
    } state_t;

    state_t st_d, st_q;
    logic   at_top, at_zero;

    always_comb begin
        st_d    = st_q;
        at_top  = (st_q.cnt >= period);
        at_zero = (st_q.cnt == '0);
        bnd     = enable && tick_en &&
                  (b2b ? (st_q.dir == DIR_DOWN && at_zero) : at_top);
        if (!enable) begin
            st_d.cnt = '0;
            st_d.dir = DIR_UP;
        end else if (tick_en) begin
            if (!b2b) begin
                st_d.dir = DIR_UP;
                st_d.cnt = at_top ? '0 : st_q.cnt + 1'b1;
            end else if (st_q.dir == DIR_UP) begin
                if (at_top) st_d.dir = DIR_DOWN;
                else        st_d.cnt = st_q.cnt + 1'b1;
            end else begin
                if (at_zero) st_d.dir = DIR_UP;
                else         st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.dir <= DIR_UP;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
    assign dir = st_q.dir;

endmodule

// File: rtl/cpwm_shadow.sv
module cpwm_shadow #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         load,
    input  logic [W-1:0] period_in,
    input  logic [W-1:0] duty_in,
    input  logic         b2b_in,
    output logic [W-1:0] period,
    output logic [W-1:0] duty,
    output logic         b2b
);

    typedef struct packed {
        logic [W-1:0] period;
        logic [W-1:0] duty;
        logic         b2b;
    } act_t;

    act_t act_d, act_q;

    always_comb begin
        act_d = act_q;
        if (!enable || load) begin
            act_d.period = period_in;
            act_d.duty   = duty_in;
            act_d.b2b    = b2b_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= act_d;
    end

    assign period = act_q.period;
    assign duty   = act_q.duty;
    assign b2b    = act_q.b2b;

endmodule

// File: rtl/cpwm_compare.sv
module cpwm_compare #(
    parameter int W = 10
) (
    input  logic         enable,
    input  logic         b2b,
    input  logic         pol_high,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] period,
    input  logic [W-1:0] duty,
    output logic         pwm
);

    logic full, active;

    always_comb begin
        full = (duty >= period);
        if (!enable)  active = 1'b0;
        else if (b2b) active = full || (cnt >= period - duty);
        else          active = (cnt <= duty);
        pwm = pol_high ? active : !active;
    end

endmodule

// File: rtl/cpwm_gen.sv
module cpwm_gen
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             enable,
    input  logic             mode_b2b,
    input  logic             pol_high,
    input  logic [CNT_W-1:0] period_in,
    input  logic [CNT_W-1:0] duty_in,
    output logic             pwm_out,
    output logic [CNT_W-1:0] cnt_out
);

    logic [CNT_W-1:0] per_act, duty_act, cnt;
    logic             b2b_act, bnd;
    dir_e             dir;

    cpwm_shadow #(.W(CNT_W)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .load      (bnd),
        .period_in (period_in),
        .duty_in   (duty_in),
        .b2b_in    (mode_b2b),
        .period    (per_act),
        .duty      (duty_act),
        .b2b       (b2b_act)
    );

    cpwm_counter #(.W(CNT_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .enable  (enable),
        .b2b     (b2b_act),
        .period  (per_act),
        .cnt     (cnt),
        .dir     (dir),
        .bnd     (bnd)
    );

    cpwm_compare #(.W(CNT_W)) u_compare (
        .enable   (enable),
        .b2b      (b2b_act),
        .pol_high (pol_high),
        .cnt      (cnt),
        .period   (per_act),
        .duty     (duty_act),
        .pwm      (pwm_out)
    );

    assign cnt_out = cnt;

endmodule

// File: rtl/cpwm_chk.sv
module cpwm_chk
    import cpwm_pkg::*;
#(
    parameter int W = 10
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick_en,
    input logic         enable,
    input logic         pol_high,
    input logic         pwm_out,
    input logic [W-1:0] cnt_out,
    input logic [W-1:0] per_act,
    input logic [W-1:0] duty_act,
    input logic         b2b_act,
    input logic         bnd,
    input dir_e         dir
);

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (cnt_out == '0 && dir == DIR_UP));

    // R1
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (pwm_out == !pol_high));

    // R2
    tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !tick_en) |=> $stable(cnt_out));

    // R3
    in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enable |-> (cnt_out <= per_act));

    // R5
    peak_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tick_en && b2b_act && dir == DIR_UP && cnt_out == per_act)
        |=> ($stable(cnt_out) && dir == DIR_DOWN));

    // R7
    full_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && duty_act >= per_act) |-> (pwm_out == pol_high));

    // R9
    buffered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !bnd) |=> ($stable(per_act) && $stable(duty_act) && $stable(b2b_act)));

endmodule

bind cpwm_gen cpwm_chk #(.W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .enable   (enable),
    .pol_high (pol_high),
    .pwm_out  (pwm_out),
    .cnt_out  (cnt_out),
    .per_act  (per_act),
    .duty_act (duty_act),
    .b2b_act  (b2b_act),
    .bnd      (bnd),
    .dir      (dir)
);

// File: tb/sim_cpwm_gen.sv
module sim_cpwm_gen;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_en = 1'b0;
    logic         enable = 1'b0;
    logic         mode_b2b = 1'b0;
    logic         pol_high = 1'b1;
    logic [W-1:0] period_in = '0;
    logic [W-1:0] duty_in = '0;
    logic         pwm_out;
    logic [W-1:0] cnt_out;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    // bench model: position within the active period
    int pos = 0, aP = 0, aD = 0;
    bit aM = 1'b0;
    bit last_tick = 1'b0, last_en = 1'b0;
    int last_cnt = 0;

    cpwm_gen #(.CNT_W(W)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .enable    (enable),
        .mode_b2b  (mode_b2b),
        .pol_high  (pol_high),
        .period_in (period_in),
        .duty_in   (duty_in),
        .pwm_out   (pwm_out),
        .cnt_out   (cnt_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000 && !done) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual %0d cycles, expected under 100000", cyc);
                finish_run();
            end
        end
    end

    task automatic step();
        bit e = enable;
        bit t = tick_en;
        int len;
        @(posedge clk);
        len = aM ? 2 * aP + 2 : aP + 1;
        if (!e) begin
            pos = 0;
            aP = int'(period_in);
            aD = int'(duty_in);
            aM = mode_b2b;
        end else if (t) begin
            pos++;
            if (pos == len) begin
                pos = 0;
                aP = int'(period_in);
                aD = int'(duty_in);
                aM = mode_b2b;
            end
        end
        last_en = e;
        last_tick = t;
        @(negedge clk);
    endtask

    task automatic check();
        int ec;
        bit act, eo;
        string tc, to;
        bit pend;
        if (!enable) begin
            ec = 0;
            eo = !pol_high;
            tc = "R1";
            to = "R1";
        end else begin
            if (aM) ec = (pos <= aP) ? pos : 2 * aP + 1 - pos;
            else    ec = pos;
            if (aM) act = (pos >= aP - aD) && (pos <= aP + aD + 1);
            else    act = (pos <= aD);
            eo = pol_high ? act : !act;
            pend = (int'(period_in) != aP) || (int'(duty_in) != aD) || (mode_b2b != aM);
            tc = aM ? "R5" : "R3";
            to = (aD >= aP) ? "R7/R8" : (aM ? "R6/R8" : "R4/R8");
            if (pend) begin
                tc = {tc, "/R9"};
                to = {to, "/R9"};
            end
        end
        n_chk++;
        if (int'(cnt_out) != ec) begin
            n_bad++;
            $display("FAIL %s cnt_out: actual %0d expected %0d (P=%0d D=%0d b2b=%0b pos=%0d)",
                     tc, cnt_out, ec, aP, aD, aM, pos);
        end
        n_chk++;
        if (pwm_out != eo) begin
            n_bad++;
            $display("FAIL %s pwm_out: actual %0b expected %0b (P=%0d D=%0d b2b=%0b pol=%0b pos=%0d)",
                     to, pwm_out, eo, aP, aD, aM, pol_high, pos);
        end
        if (enable && last_en && !last_tick) begin
            n_chk++;
            if (int'(cnt_out) != last_cnt) begin
                n_bad++;
                $display("FAIL R2 hold without tick: actual %0d expected %0d", cnt_out, last_cnt);
            end
        end
        last_cnt = int'(cnt_out);
    endtask

    initial begin
        int k = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        n_chk++;
        if (cnt_out != '0 || pwm_out != 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: actual cnt=%0d pwm=%0b expected cnt=0 pwm=0", cnt_out, pwm_out);
        end
        rst_n = 1'b1;
        step();
        step();
        check();

        for (int m = 0; m < 2; m++) begin
            for (int pl = 0; pl < 2; pl++) begin
                for (int p = 0; p < 6; p++) begin
                    for (int d = 0; d < 7; d++) begin
                        // settings change at whatever position the run has reached
                        mode_b2b  = m[0];
                        pol_high  = pl[0];
                        period_in = W'(p);
                        duty_in   = W'(d);
                        if (k % 7 == 3) enable = 1'b0;
                        for (int c = 0; c < 30; c++) begin
                            tick_en = ((c + k) % 5) != 3;
                            if (c == 2) enable = 1'b1;
                            step();
                            check();
                        end
                        k++;
                    end
                end
            end
        end

        // R8: polarity flip acts immediately
        enable = 1'b1;
        pol_high = ~pol_high;
        #1;
        check();
        enable = 1'b0;
        step();
        check();

        done = 1'b1;
        finish_run();
    end

endmodule